// File: doc/BRIEF.md
# I2C Slave with Status Register

This block is the target side of a two-wire serial bus, tied to a host CPU by a small register port. It watches the SCL and SDA lines through synchronisers and finds START and STOP conditions. It collects the first byte of a transfer as a 7-bit address followed by a direction bit, and compares the address against an own-address register that the host programs. On a match it acknowledges the address, records the direction, raises a one-cycle interrupt and, when enabled, a wake-up request. The host then chooses whether the block receives or transmits the data bytes that follow.

While receiving, the block assembles each byte MSB first and then drives the host-chosen acknowledge level during the ninth clock. While transmitting, it shifts a host-supplied byte out MSB first and samples the master's acknowledge on the ninth clock. A control/status byte gives the host one view of the transfer flags together with its own control bits. A register-port command returns the transfer side to its idle state. The host's control choices survive that command.

Top module: `i2c_slave_csr`

## Requirements
- R1: After reset the status byte (register select 0) reads 8'h81, and `irq`, `wake` and `sda_oe` are 0.
- R2: Register select 0 is the status byte: bit 7 transfer done, bit 6 address matched, bit 5 bus busy, bit 4 transmit select, bit 3 acknowledge level to send, bit 2 captured direction, bit 1 wake enable, bit 0 received not-acknowledge. A host write to it changes only bits 4, 3 and 1. Select 1 writes the transmit byte and reads the last received byte. Select 2 holds the 7-bit own address in bits 6:0. A write to select 3 is the slave reset.
- R3: A START (SDA falling while SCL is high) sets bit 5 and clears bit 7. A STOP (SDA rising while SCL is high) clears bits 5 and 6.
- R4: The first byte after START is taken as 7 address bits, MSB first, followed by the direction bit. If the address equals the own address, bit 6 goes to 1 and bit 2 takes the direction bit. Bit 7 goes to 1 with an `irq` pulse, and the slave pulls SDA low (`sda_oe`=1) during the 9th clock.
- R5: If the address differs, bit 6 stays 0 and bit 7 stays 0, and no `irq` is raised. The slave does not drive SDA at all until the next START.
- R6: When bit 4 is 0, each data byte is received MSB first and becomes readable at select 1, with bit 7 set and an `irq` pulse. During the 9th clock the slave drives SDA low if bit 3 is 0 and leaves it released if bit 3 is 1.
- R7: When bit 4 is 0x1 at the end of an acknowledge clock, the transmit byte is sent MSB first, each bit changing after an SCL fall. Bit 7 reads 0 while the byte is shifting, and goes to 1 with an `irq` pulse after the 8th bit.
- R8: On the 9th clock of a transmitted byte, bit 0 takes the SDA level. If that level is 1 (no acknowledge), the slave stops driving until the next START.
- R9: With bit 1 set, a matching address raises `wake`, which stays high until the host clears bit 1. A non-matching address does not raise it.
- R10: A slave reset sets bits 7 and 0 to 1, clears bits 6, 5 and 2, and releases SDA. Bits 4, 3 and 1 keep their values.
- R11: `irq` is high for exactly one clock per completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Host register select |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for the selected register |
| irq | output | 1 | One-cycle pulse per completed byte |
| wake | output | 1 | Wake-up request after an address match |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A matching write transfer is tried with both acknowledge settings, which shows that the 9th-clock drive follows bit 3 and not a fixed level. A foreign address is followed by a further byte, and the bench reads the line back as all ones, which separates "released until START" from "released only during the ack slot". A read transfer ends with one acknowledged and one refused byte, so the received-ack flag is seen taking both values and the refusal is seen to silence the slave. Wake-up is tried after a foreign address and after a matching one. A slave reset is issued while the slave holds SDA low, which shows it both releases the bus and keeps the host's control bits.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [3:0] {
    LK_IDLE,
    LK_ADDR,
    LK_ACKW,
    LK_ACK,
    LK_RX,
    LK_TX,
    LK_TXACK,
    LK_TXEND,
    LK_SKIP
  } link_state_t;

  localparam logic [1:0] SEL_CSR  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_OWN  = 2'd2;
  localparam logic [1:0] SEL_SRST = 2'd3;

  localparam int B_SELTX = 4;
  localparam int B_ACKLV = 3;
  localparam int B_WAKE  = 1;

  function automatic logic is_start(input logic scl_now, input logic scl_old,
                                    input logic sda_now, input logic sda_old);
    return scl_now & scl_old & sda_old & ~sda_now;
  endfunction

  function automatic logic is_stop(input logic scl_now, input logic scl_old,
                                   input logic sda_now, input logic sda_old);
    return scl_now & scl_old & ~sda_old & sda_now;
  endfunction

  function automatic logic [7:0] csr_pack(input logic done, input logic match,
                                          input logic busy, input logic seltx,
                                          input logic acklv, input logic dir,
                                          input logic wake_en, input logic rxnack);
    return {done, match, busy, seltx, acklv, dir, wake_en, rxnack};
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  import i2cs_pkg::*;

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe    <= '1;
        prev[g] <= 1'b1;
      end else begin
        pipe    <= {pipe[STAGES-2:0], raw[g]};
        prev[g] <= pipe[STAGES-1];
      end
    end
    assign synced[g] = pipe[STAGES-1];
  end

  logic scl_s;
  assign scl_s    = synced[0];
  assign sda_s    = synced[1];
  assign scl_rise = scl_s & ~prev[0];
  assign scl_fall = ~scl_s & prev[0];
  assign start_ev = is_start(scl_s, prev[0], sda_s, prev[1]);
  assign stop_ev  = is_stop(scl_s, prev[0], sda_s, prev[1]);

endmodule

// File: rtl/i2cs_link.sv
module i2cs_link #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sel_tx,
  input  logic              tx_ack,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sda_oe,
  output logic              addr_ev,
  output logic              addr_hit,
  output logic              addr_rw,
  output logic              rx_done_ev,
  output logic [DATA_W-1:0] rx_byte,
  output logic              tx_done_ev,
  output logic              nack_ev,
  output logic              nack_val,
  output logic              shift_begin_ev
);
  import i2cs_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  function automatic logic addr_matches(input logic [DATA_W-1:0] b,
                                        input logic [ADDR_W-1:0] own);
    return b[DATA_W-1:1] == own;
  endfunction

  link_state_t       st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic              ack_lo;
  logic [DATA_W-1:0] shifted;
  logic              last;

  assign shifted = {shreg[DATA_W-2:0], sda_s};
  assign last    = (cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= LK_IDLE;
      cnt            <= '0;
      shreg          <= '0;
      ack_lo         <= 1'b0;
      sda_oe         <= 1'b0;
      addr_ev        <= 1'b0;
      addr_hit       <= 1'b0;
      addr_rw        <= 1'b0;
      rx_done_ev     <= 1'b0;
      rx_byte        <= '0;
      tx_done_ev     <= 1'b0;
      nack_ev        <= 1'b0;
      nack_val       <= 1'b0;
      shift_begin_ev <= 1'b0;
    end else begin
      addr_ev        <= 1'b0;
      rx_done_ev     <= 1'b0;
      tx_done_ev     <= 1'b0;
      nack_ev        <= 1'b0;
      shift_begin_ev <= 1'b0;
      if (soft_rst) begin
        st     <= LK_IDLE;
        sda_oe <= 1'b0;
        cnt    <= '0;
      end else if (start_ev) begin
        st     <= LK_ADDR;
        sda_oe <= 1'b0;
        cnt    <= '0;
      end else if (stop_ev) begin
        st     <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          LK_ADDR: if (scl_rise) begin
            shreg <= shifted;
            if (last) begin
              addr_ev  <= 1'b1;
              addr_hit <= addr_matches(shifted, own_addr);
              addr_rw  <= sda_s;
              ack_lo   <= addr_matches(shifted, own_addr);
              st       <= addr_matches(shifted, own_addr) ? LK_ACKW : LK_SKIP;
              cnt      <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          LK_ACKW: if (scl_fall) begin
            st     <= LK_ACK;
            sda_oe <= ack_lo;
          end
          LK_ACK: if (scl_fall) begin
            shift_begin_ev <= 1'b1;
            cnt            <= '0;
            if (sel_tx) begin
              shreg  <= tx_data;
              sda_oe <= ~tx_data[DATA_W-1];
              st     <= LK_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= LK_RX;
            end
          end
          LK_RX: if (scl_rise) begin
            shreg <= shifted;
            if (last) begin
              rx_done_ev <= 1'b1;
              rx_byte    <= shifted;
              ack_lo     <= ~tx_ack;
              st         <= LK_ACKW;
              cnt        <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          LK_TX: if (scl_fall) begin
            if (last) begin
              sda_oe     <= 1'b0;
              tx_done_ev <= 1'b1;
              st         <= LK_TXACK;
              cnt        <= '0;
            end else begin
              cnt    <= cnt + 1'b1;
              shreg  <= {shreg[DATA_W-2:0], 1'b0};
              sda_oe <= ~shreg[DATA_W-2];
            end
          end
          LK_TXACK: if (scl_rise) begin
            nack_ev  <= 1'b1;
            nack_val <= sda_s;
            st       <= sda_s ? LK_SKIP : LK_TXEND;
          end
          LK_TXEND: if (scl_fall) begin
            shift_begin_ev <= 1'b1;
            cnt            <= '0;
            shreg          <= tx_data;
            sda_oe         <= ~tx_data[DATA_W-1];
            st             <= LK_TX;
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cs_csr_bank.sv
module i2cs_csr_bank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              addr_ev,
  input  logic              addr_hit,
  input  logic              addr_rw,
  input  logic              rx_done_ev,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_done_ev,
  input  logic              nack_ev,
  input  logic              nack_val,
  input  logic              shift_begin_ev,
  output logic              soft_rst,
  output logic [ADDR_W-1:0] own_addr,
  output logic              sel_tx,
  output logic              tx_ack,
  output logic              wake_en,
  output logic [DATA_W-1:0] tx_data,
  output logic [7:0]        status,
  output logic              irq,
  output logic              wake
);
  import i2cs_pkg::*;

  logic f_done, f_match, f_busy, f_dir, f_rxnack, wake_req;
  logic hit_ev, byte_set;

  assign soft_rst = reg_wr && (reg_sel == SEL_SRST);
  assign hit_ev   = addr_ev & addr_hit;
  assign byte_set = hit_ev | rx_done_ev | tx_done_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_done   <= 1'b1;
      f_match  <= 1'b0;
      f_busy   <= 1'b0;
      f_dir    <= 1'b0;
      f_rxnack <= 1'b1;
      irq      <= 1'b0;
    end else if (soft_rst) begin
      f_done   <= 1'b1;
      f_match  <= 1'b0;
      f_busy   <= 1'b0;
      f_dir    <= 1'b0;
      f_rxnack <= 1'b1;
      irq      <= 1'b0;
    end else if (start_ev) begin
      f_done  <= 1'b0;
      f_match <= 1'b0;
      f_busy  <= 1'b1;
      irq     <= 1'b0;
    end else if (stop_ev) begin
      f_match <= 1'b0;
      f_busy  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= byte_set;
      if (byte_set) f_done <= 1'b1;
      else if (shift_begin_ev) f_done <= 1'b0;
      if (hit_ev) begin
        f_match <= 1'b1;
        f_dir   <= addr_rw;
      end
      if (nack_ev) f_rxnack <= nack_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_tx   <= 1'b0;
      tx_ack   <= 1'b0;
      wake_en  <= 1'b0;
      tx_data  <= '0;
      own_addr <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        SEL_CSR: begin
          sel_tx  <= reg_wdata[B_SELTX];
          tx_ack  <= reg_wdata[B_ACKLV];
          wake_en <= reg_wdata[B_WAKE];
        end
        SEL_DATA: tx_data  <= reg_wdata;
        SEL_OWN:  own_addr <= reg_wdata[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_req <= 1'b0;
    else if (!wake_en) wake_req <= 1'b0;
    else if (hit_ev && !soft_rst) wake_req <= 1'b1;
  end

  assign wake   = wake_req & wake_en;
  assign status = csr_pack(f_done, f_match, f_busy, sel_tx, tx_ack, f_dir, wake_en, f_rxnack);

  always_comb begin
    case (reg_sel)
      SEL_CSR:  reg_rdata = status;
      SEL_DATA: reg_rdata = rx_byte;
      SEL_OWN:  reg_rdata = {{(DATA_W-ADDR_W){1'b0}}, own_addr};
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/i2c_slave_csr.sv
module i2c_slave_csr #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              wake,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe
);
  localparam int ADDR_W = DATA_W - 1;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic soft_rst, sel_tx, tx_ack, wake_en;
  logic addr_ev, addr_hit, addr_rw, rx_done_ev, tx_done_ev;
  logic nack_ev, nack_val, shift_begin_ev;
  logic [ADDR_W-1:0] own_addr;
  logic [DATA_W-1:0] tx_data, rx_byte;
  logic [7:0]        status;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cs_link #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_link (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev), .own_addr(own_addr),
    .sel_tx(sel_tx), .tx_ack(tx_ack), .tx_data(tx_data),
    .sda_oe(sda_oe), .addr_ev(addr_ev), .addr_hit(addr_hit), .addr_rw(addr_rw),
    .rx_done_ev(rx_done_ev), .rx_byte(rx_byte), .tx_done_ev(tx_done_ev),
    .nack_ev(nack_ev), .nack_val(nack_val), .shift_begin_ev(shift_begin_ev)
  );

  i2cs_csr_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .start_ev(start_ev), .stop_ev(stop_ev), .addr_ev(addr_ev),
    .addr_hit(addr_hit), .addr_rw(addr_rw), .rx_done_ev(rx_done_ev),
    .rx_byte(rx_byte), .tx_done_ev(tx_done_ev), .nack_ev(nack_ev),
    .nack_val(nack_val), .shift_begin_ev(shift_begin_ev),
    .soft_rst(soft_rst), .own_addr(own_addr), .sel_tx(sel_tx),
    .tx_ack(tx_ack), .wake_en(wake_en), .tx_data(tx_data),
    .status(status), .irq(irq), .wake(wake)
  );

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       soft_rst,
  input logic       addr_ev,
  input logic       addr_hit,
  input logic       irq,
  input logic       wake,
  input logic       wake_en,
  input logic [7:0] status,
  input logic       sda_oe,
  input logic       sel_tx,
  input logic       tx_ack
);

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R11
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> status[7]); // R4
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n) (start_ev && !soft_rst) |=> status[5]); // R3
  AST_BUSY_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n) (stop_ev && !start_ev) |=> !status[5]); // R3
  AST_QUIET_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n) !status[5] |-> !sda_oe); // R10
  AST_NO_ACK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n) (addr_ev && !addr_hit) |=> !sda_oe); // R5
  AST_MATCH_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[6]) |-> $past(addr_ev && addr_hit)); // R4
  AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) wake |-> wake_en); // R9
  AST_SRST_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> (sel_tx == $past(sel_tx)) && (tx_ack == $past(tx_ack))); // R10
  AST_SRST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> status[7] && !status[6] && !status[5] && !status[2] && status[0]); // R10

endmodule

bind i2c_slave_csr i2cs_checker u_i2cs_checker (
  .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
  .soft_rst(soft_rst), .addr_ev(addr_ev), .addr_hit(addr_hit), .irq(irq),
  .wake(wake), .wake_en(wake_en), .status(status), .sda_oe(sda_oe),
  .sel_tx(sel_tx), .tx_ack(tx_ack)
);

// File: tb/test_i2c_slave_csr.sv
`timescale 1ns/1ps
module test_i2c_slave_csr;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h3A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, wake, sda_oe;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_line;

  assign sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_slave_csr i_i2c_slave_csr (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .wake(wake),
    .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  int irq_seen = 0;
  int e_irq = 0;
  logic irq_last = 1'b0;
  logic quiet = 1'b0;

  logic e_done = 1'b1, e_match = 1'b0, e_busy = 1'b0, e_dir = 1'b0, e_rxnack = 1'b1;
  logic m_seltx = 1'b0, m_acklv = 1'b0, m_wake = 1'b0;

  function automatic logic [7:0] exp_status();
    return {e_done, e_match, e_busy, m_seltx, m_acklv, e_dir, m_wake, e_rxnack};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // per-clock model comparison: irq width (R11) and bus silence (R5, R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_seen++;
      if (irq && irq_last) begin
        n_fail++;
        $display("FAIL R11 actual=irq high two clocks expected=single pulse");
      end
      if (quiet && sda_oe) begin
        n_fail++;
        $display("FAIL R5_R8 actual=sda_oe 1 expected=0 while ignoring bus");
      end
      irq_last = irq;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic set_ctrl(input logic tx, input logic ack, input logic wk);
    host_write(2'd0, {3'b000, tx, ack, 1'b0, wk, 1'b0});
    m_seltx = tx; m_acklv = ack; m_wake = wk;
  endtask

  task automatic check_status(input string req);
    logic [7:0] d;
    wait_clk(2);
    host_read(2'd0, d);
    chk(req, d, exp_status());
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b1; wait_clk(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wait_clk(Q);
    m_scl = 1'b1; wait_clk(2 * Q);
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic read_bit(output logic b);
    m_sda = 1'b1; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    b = sda_line; wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      read_bit(b);
      v[i] = b;
    end
  endtask

  initial begin
    logic [7:0] d;
    logic b;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    host_read(2'd0, d);
    chk("R1 status", d, 8'h81);
    chk("R1 irq/wake/oe", {5'd0, irq, wake, sda_oe}, 8'h00);

    // R2 register map and read-only bits
    host_write(2'd2, {1'b0, OWN});
    host_read(2'd2, d);
    chk("R2 own address", d, {1'b0, OWN});
    host_write(2'd0, 8'hFF);
    m_seltx = 1'b1; m_acklv = 1'b1; m_wake = 1'b1;
    check_status("R2 write ff");
    set_ctrl(1'b0, 1'b0, 1'b0);
    check_status("R2 write 00");

    // R3/R4/R6 matching write transfer
    bus_start();
    e_busy = 1'b1; e_done = 1'b0; e_match = 1'b0;
    check_status("R3 start");
    send_byte({OWN, 1'b0});
    e_done = 1'b1; e_match = 1'b1; e_dir = 1'b0; e_irq++;
    check_status("R4 address hit");
    chk("R4 irq count", 8'(irq_seen), 8'(e_irq));
    chk("R4 ack drive", {7'd0, sda_oe}, 8'h01);
    read_bit(b);
    chk("R4 address ack", {7'd0, b}, 8'h00);
    e_done = 1'b0;
    check_status("R7 done low while shifting");
    send_byte(8'hA5);
    e_done = 1'b1; e_irq++;
    host_read(2'd1, d);
    chk("R6 rx byte a5", d, 8'hA5);
    read_bit(b);
    chk("R6 ack level 0", {7'd0, b}, 8'h00);
    e_done = 1'b0;
    set_ctrl(1'b0, 1'b1, 1'b0);
    send_byte(8'h3C);
    e_done = 1'b1; e_irq++;
    host_read(2'd1, d);
    chk("R6 rx byte 3c", d, 8'h3C);
    read_bit(b);
    chk("R6 ack level 1", {7'd0, b}, 8'h01);
    e_done = 1'b0;
    bus_stop();
    e_busy = 1'b0; e_match = 1'b0;
    check_status("R3 stop");
    chk("R11 irq count", 8'(irq_seen), 8'(e_irq));
    set_ctrl(1'b0, 1'b0, 1'b0);

    // R5 foreign address
    bus_start();
    e_busy = 1'b1; e_done = 1'b0;
    send_byte({7'h11, 1'b1});
    quiet = 1'b1;
    check_status("R5 miss flags");
    read_bit(b);
    chk("R5 no ack", {7'd0, b}, 8'h01);
    read_byte(d);
    chk("R5 bus released", d, 8'hFF);
    chk("R5 irq count", 8'(irq_seen), 8'(e_irq));
    bus_stop();
    quiet = 1'b0;
    e_busy = 1'b0;

    // R7/R8 read transfer
    host_write(2'd1, 8'hC3);
    set_ctrl(1'b1, 1'b0, 1'b0);
    bus_start();
    e_busy = 1'b1; e_done = 1'b0;
    send_byte({OWN, 1'b1});
    e_done = 1'b1; e_match = 1'b1; e_dir = 1'b1; e_irq++;
    check_status("R4 read address");
    read_bit(b);
    chk("R4 read ack", {7'd0, b}, 8'h00);
    read_byte(d);
    chk("R7 tx byte c3", d, 8'hC3);
    e_irq++;
    check_status("R7 done after byte");
    host_write(2'd1, 8'h5E);
    send_bit(1'b0);
    e_rxnack = 1'b0; e_done = 1'b0;
    check_status("R8 master ack");
    read_byte(d);
    chk("R7 tx byte 5e", d, 8'h5E);
    e_irq++; e_done = 1'b1;
    send_bit(1'b1);
    e_rxnack = 1'b1;
    quiet = 1'b1;
    check_status("R8 master nack");
    read_byte(d);
    chk("R8 silent after nack", d, 8'hFF);
    bus_stop();
    quiet = 1'b0;
    e_busy = 1'b0; e_match = 1'b0;
    chk("R11 irq count tx", 8'(irq_seen), 8'(e_irq));

    // R9 wake-up
    set_ctrl(1'b0, 1'b0, 1'b1);
    bus_start();
    send_byte({7'h12, 1'b0});
    wait_clk(4);
    chk("R9 no wake on miss", {7'd0, wake}, 8'h00);
    bus_stop();
    bus_start();
    send_byte({OWN, 1'b0});
    e_irq++;
    wait_clk(4);
    chk("R9 wake on hit", {7'd0, wake}, 8'h01);
    read_bit(b);
    bus_stop();
    chk("R9 wake held", {7'd0, wake}, 8'h01);
    set_ctrl(1'b0, 1'b0, 1'b0);
    wait_clk(2);
    chk("R9 wake cleared", {7'd0, wake}, 8'h00);

    // R10 slave reset while slave drives the ack
    set_ctrl(1'b1, 1'b1, 1'b0);
    bus_start();
    send_byte({OWN, 1'b1});
    e_irq++;
    chk("R4 driving ack", {7'd0, sda_oe}, 8'h01);
    host_write(2'd3, 8'h00);
    e_done = 1'b1; e_match = 1'b0; e_busy = 1'b0; e_dir = 1'b0; e_rxnack = 1'b1;
    check_status("R10 flags after reset");
    chk("R10 bus released", {7'd0, sda_oe}, 8'h00);
    quiet = 1'b1;
    read_bit(b);
    chk("R10 ignores bus", {7'd0, b}, 8'h01);
    bus_stop();
    quiet = 1'b0;
    check_status("R10 idle after stop");
    chk("R11 irq total", 8'(irq_seen), 8'(e_irq));

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule